// File: doc/BRIEF.md
# Code-Block Stripe Scan Generator

This block produces the sequence of coefficient coordinates that an embedded block coder walks through inside one code-block. A code-block is cut into horizontal bands four rows tall. Inside a band, the scan takes one column at a time, from left to right, and covers all four rows of that column, top first, before it moves right. Bands are taken from the top of the block to the bottom. One full walk of the block is one coding pass. Each bit-plane gets three such passes, and the bit-planes are walked from the most significant down to the least significant.

A controller sets the block geometry (columns, rows) and the number of bit-planes on the configuration inputs and pulses `start` while the generator is idle. The generator then presents one coordinate per accepted beat on a valid/ready interface. Each beat carries row, column, bit-plane and pass indices, a first-beat marker, and end-of-band, end-of-pass and end-of-block markers. A geometry the scan cannot cover raises an error flag, and in that case no scan starts. Significance decisions and the coding itself belong to the consumer.

Top module: `cb_scan_gen`

## Requirements
- R1: After reset, `out_valid` and `cfg_err` are 0.
- R2: A `start` pulse while idle with a legal configuration makes `out_valid` 1 on the next clock. The first beat is row 0, column 0, pass 0, bit-plane `cfg_planes-1`, with `out_first` 1. `out_first` is 0 on every later beat.
- R3: Inside a band, the row steps by one through the band's four rows (row mod 4 = 0,1,2,3) while the column is held. The column then steps by one, left to right, from 0 to `cfg_cols-1`, and the row returns to the top of the band.
- R4: Bands are visited from top to bottom: after column `cfg_cols-1`, row mod 4 = 3, the next beat is column 0 of the following band. `out_eos` is 1 exactly on that last beat of each band.
- R5: Each bit-plane runs three passes, coded 0, 1 and 2 in that order. Each pass repeats the full band scan. `out_eop` is 1 exactly on the last beat of a pass (last row, last column).
- R6: After pass 2 the bit-plane index decreases by one, running from `cfg_planes-1` down to 0.
- R7: `out_eob` is 1 only on the final beat (bit-plane 0, pass 2, last row, last column). Once that beat is accepted, `out_valid` is 0 on the next clock.
- R8: While `out_valid` is 1 and `out_ready` is 0, every output holds its value.
- R9: A start with a row count that is zero or not a multiple of 4, or with a zero or oversized column count, row count or bit-plane count, sets `cfg_err` to 1 and does not assert `out_valid`. The next legal start clears `cfg_err`.
- R10: A `start` pulse during a running scan is ignored, and the scan continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a scan; taken only while idle |
| cfg_cols | input | CW+1 | Code-block width in columns (1..MAX_W) |
| cfg_rows | input | RW+1 | Code-block height in rows (multiple of 4, up to MAX_H) |
| cfg_planes | input | PW+1 | Number of bit-planes (1..MAX_BP) |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_valid | output | 1 | A coordinate is presented |
| out_row | output | RW | Row index |
| out_col | output | CW | Column index |
| out_plane | output | PW | Bit-plane index, counting down |
| out_pass | output | 2 | Coding pass 0, 1 or 2 |
| out_first | output | 1 | First beat of the block |
| out_eos | output | 1 | Last beat of a band |
| out_eop | output | 1 | Last beat of a pass |
| out_eob | output | 1 | Last beat of the block |
| cfg_err | output | 1 | Last start request had an illegal configuration |

## Verification
The bench targets several boundary conditions. A single-column block: a design that mishandled it would fail to wrap the column and would never reach the next band. A single-band block: here `out_eos` and `out_eop` coincide, and a wrong marker decode would drop one of them. A single bit-plane block: there the first plane is also the last, and a bad down-count would wrap the plane index and run forever. Random back-pressure catches a design that advances or changes its fields while stalled. A start pulse in mid-scan would corrupt the coordinate stream if it reloaded the counters. Row counts of 0 and 6 and out-of-range widths must raise the error flag and keep the valid output low.

// File: rtl/cbs_pkg.sv
// Shared definitions for the code-block stripe scan generator.
// Assumes nothing beyond a four-row band height fixed by the coding scheme.
package cbs_pkg;
    localparam int BAND_H = 4;

    typedef enum logic [1:0] {
        PASS_SIG = 2'd0,
        PASS_REF = 2'd1,
        PASS_CLN = 2'd2
    } pass_e;
endpackage

// File: rtl/cbs_cfg_check.sv
// Combinational legality check of a scan configuration.
// Assumes MAX_H is a multiple of four; the result is only sampled on a start.
module cbs_cfg_check #(
    parameter int MAX_W  = 64,
    parameter int MAX_H  = 64,
    parameter int MAX_BP = 16,
    parameter int CW     = 6,
    parameter int RW     = 6,
    parameter int PW     = 4
) (
    input  logic [CW:0] cols,
    input  logic [RW:0] rows,
    input  logic [PW:0] planes,
    output logic        ok
);
    localparam logic [CW:0] LIM_W  = MAX_W[CW:0];
    localparam logic [RW:0] LIM_H  = MAX_H[RW:0];
    localparam logic [PW:0] LIM_BP = MAX_BP[PW:0];

    // Legal when every count is non-zero, within bounds and rows fill whole bands.
    always_comb begin
        ok = (cols != '0) && (cols <= LIM_W)
          && (rows != '0) && (rows <= LIM_H) && (rows[1:0] == 2'b00)
          && (planes != '0) && (planes <= LIM_BP);
    end
endmodule

// File: rtl/cbs_band_walk.sv
// Walks one pass: four rows down a column, columns left to right, bands top to bottom.
// Assumes cols_m1 and last_base were latched from a legal configuration.
module cbs_band_walk #(
    parameter int CW = 6,
    parameter int RW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [CW-1:0] cols_m1,
    input  logic [RW-1:0] last_base,
    output logic [RW-1:0] row,
    output logic [CW-1:0] col,
    output logic          at_eos,
    output logic          at_eop
);
    logic [1:0]    sub_q;
    logic [CW-1:0] col_q;
    logic [RW-1:0] base_q;

    // Band and pass end decode from the current position.
    always_comb begin
        at_eos = (sub_q == 2'd3) && (col_q == cols_m1);
        at_eop = at_eos && (base_q == last_base);
        row    = {base_q[RW-1:2], sub_q};
        col    = col_q;
    end

    // Advance the position by one coordinate per accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sub_q  <= '0;
            col_q  <= '0;
            base_q <= '0;
        end else if (step) begin
            if (sub_q != 2'd3) begin
                sub_q <= sub_q + 2'd1;
            end else begin
                sub_q <= '0;
                if (col_q != cols_m1) begin
                    col_q <= col_q + 1'b1;
                end else begin
                    col_q  <= '0;
                    base_q <= at_eop ? '0 : base_q + RW'(cbs_pkg::BAND_H);
                end
            end
        end
    end
endmodule

// File: rtl/cbs_plane_pass.sv
// Sequences three coding passes per bit-plane, bit-planes counting down to zero.
// Assumes step is raised only on the final beat of a pass.
module cbs_plane_pass #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] top_plane,
    input  logic          step,
    output logic [1:0]    pass,
    output logic [PW-1:0] plane,
    output logic          at_last
);
    import cbs_pkg::*;

    pass_e         pass_q;
    logic [PW-1:0] plane_q;

    // Last pass of the last plane closes the block.
    always_comb begin
        pass    = pass_q;
        plane   = plane_q;
        at_last = (pass_q == PASS_CLN) && (plane_q == '0);
    end

    // Move to the next pass, or to the next lower plane after the third pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q  <= PASS_SIG;
            plane_q <= '0;
        end else if (load) begin
            pass_q  <= PASS_SIG;
            plane_q <= top_plane;
        end else if (step) begin
            case (pass_q)
                PASS_SIG: pass_q <= PASS_REF;
                PASS_REF: pass_q <= PASS_CLN;
                default: begin
                    pass_q  <= PASS_SIG;
                    plane_q <= plane_q - 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/cb_scan_gen.sv
// Top of the code-block stripe scan generator: presents one coefficient
// coordinate per valid/ready beat. Assumes MAX_H is a multiple of four,
// MAX_H >= 4 and MAX_BP >= 2. A start is honoured only while idle.
module cb_scan_gen #(
    parameter int MAX_W  = 64,
    parameter int MAX_H  = 64,
    parameter int MAX_BP = 16,
    localparam int CW = (MAX_W > 1) ? $clog2(MAX_W) : 1,
    localparam int RW = $clog2(MAX_H),
    localparam int PW = $clog2(MAX_BP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW:0]   cfg_cols,
    input  logic [RW:0]   cfg_rows,
    input  logic [PW:0]   cfg_planes,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [RW-1:0] out_row,
    output logic [CW-1:0] out_col,
    output logic [PW-1:0] out_plane,
    output logic [1:0]    out_pass,
    output logic          out_first,
    output logic          out_eos,
    output logic          out_eop,
    output logic          out_eob,
    output logic          cfg_err
);
    logic          cfg_ok;
    logic          launch;
    logic          accept;
    logic          valid_q;
    logic          first_q;
    logic          err_q;
    logic [CW-1:0] cols_m1_q;
    logic [RW-1:0] last_base_q;
    logic [PW-1:0] top_plane_q;
    logic          eos_w;
    logic          eop_w;
    logic          last_pp_w;
    logic [RW-1:0] row_w;
    logic [CW-1:0] col_w;
    logic [1:0]    pass_w;
    logic [PW-1:0] plane_w;

    cbs_cfg_check #(
        .MAX_W(MAX_W), .MAX_H(MAX_H), .MAX_BP(MAX_BP),
        .CW(CW), .RW(RW), .PW(PW)
    ) u_cfg (
        .cols(cfg_cols), .rows(cfg_rows), .planes(cfg_planes), .ok(cfg_ok)
    );

    // Handshake and launch conditions.
    always_comb begin
        launch = start && !valid_q && cfg_ok;
        accept = valid_q && out_ready;
    end

    // Capture geometry on a legal start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cols_m1_q   <= '0;
            last_base_q <= '0;
            top_plane_q <= '0;
        end else if (launch) begin
            cols_m1_q   <= CW'(cfg_cols - 1'b1);
            last_base_q <= RW'(cfg_rows - (RW+1)'(cbs_pkg::BAND_H));
            top_plane_q <= PW'(cfg_planes - 1'b1);
        end
    end

    cbs_band_walk #(.CW(CW), .RW(RW)) u_band (
        .clk(clk), .rst_n(rst_n), .clear(launch), .step(accept),
        .cols_m1(cols_m1_q), .last_base(last_base_q),
        .row(row_w), .col(col_w), .at_eos(eos_w), .at_eop(eop_w)
    );

    cbs_plane_pass #(.PW(PW)) u_pp (
        .clk(clk), .rst_n(rst_n), .load(launch),
        .top_plane(PW'(cfg_planes - 1'b1)), .step(accept && eop_w),
        .pass(pass_w), .plane(plane_w), .at_last(last_pp_w)
    );

    // Run state, first-beat marker and configuration error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            first_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (start && !valid_q) begin
            valid_q <= cfg_ok;
            first_q <= cfg_ok;
            err_q   <= !cfg_ok;
        end else if (accept) begin
            first_q <= 1'b0;
            if (eop_w && last_pp_w) begin
                valid_q <= 1'b0;
            end
        end
    end

    // Drive the beat; markers are qualified by valid.
    always_comb begin
        out_valid = valid_q;
        out_row   = row_w;
        out_col   = col_w;
        out_plane = plane_w;
        out_pass  = pass_w;
        out_first = valid_q && first_q;
        out_eos   = valid_q && eos_w;
        out_eop   = valid_q && eop_w;
        out_eob   = valid_q && eop_w && last_pp_w;
        cfg_err   = err_q;
    end
endmodule

// File: rtl/cbs_scan_gen_chk.sv
// Property checker for cb_scan_gen, attached through bind below.
module cbs_scan_gen_chk #(
    parameter int CW = 6,
    parameter int RW = 6,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          out_ready,
    input logic          out_valid,
    input logic [RW-1:0] out_row,
    input logic [CW-1:0] out_col,
    input logic [PW-1:0] out_plane,
    input logic [1:0]    out_pass,
    input logic          out_first,
    input logic          out_eos,
    input logic          out_eop,
    input logic          out_eob,
    input logic          cfg_err
);
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_col)
            && $stable(out_plane) && $stable(out_pass))); // R8
    AST_ROW_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_row[1:0] != 2'd3) |=>
            (out_row == $past(out_row) + 1'b1 && out_col == $past(out_col))); // R3
    AST_COL_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_row[1:0] == 2'd3 && !out_eos) |=>
            (out_row[1:0] == 2'd0 && out_col == $past(out_col) + 1'b1)); // R3
    AST_BAND_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eos && !out_eop) |=>
            (out_valid && out_col == '0 && out_row == $past(out_row) + 1'b1)); // R4
    AST_PASS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop && !out_eob) |=>
            (out_valid && out_row == '0 && out_col == '0)); // R5
    AST_END_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        out_eob |-> (out_eop && out_eos && out_plane == '0 && out_pass == 2'd2)); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eob && out_ready) |=> !out_valid); // R7
    AST_FIRST_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> (out_row == '0 && out_col == '0 && out_pass == 2'd0)); // R2
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !out_valid); // R9
endmodule

bind cb_scan_gen cbs_scan_gen_chk #(.CW(CW), .RW(RW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_ready(out_ready), .out_valid(out_valid),
    .out_row(out_row), .out_col(out_col), .out_plane(out_plane), .out_pass(out_pass),
    .out_first(out_first), .out_eos(out_eos), .out_eop(out_eop), .out_eob(out_eob),
    .cfg_err(cfg_err)
);

// File: tb/cb_scan_gen_tb.sv
// Sweeps every legal geometry of a small configuration under random back-pressure.
module cb_scan_gen_tb;
    localparam int MAX_W = 8, MAX_H = 8, MAX_BP = 4;
    localparam int CW = 3, RW = 3, PW = 2;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, out_ready = 1'b0;
    logic [CW:0] cfg_cols = '0;
    logic [RW:0] cfg_rows = '0;
    logic [PW:0] cfg_planes = '0;
    logic out_valid, out_first, out_eos, out_eop, out_eob, cfg_err;
    logic [RW-1:0] out_row;
    logic [CW-1:0] out_col;
    logic [PW-1:0] out_plane;
    logic [1:0] out_pass;

    int errors = 0, checks = 0;
    bit finished = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    cb_scan_gen #(.MAX_W(MAX_W), .MAX_H(MAX_H), .MAX_BP(MAX_BP)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_cols(cfg_cols),
        .cfg_rows(cfg_rows), .cfg_planes(cfg_planes), .out_ready(out_ready),
        .out_valid(out_valid), .out_row(out_row), .out_col(out_col),
        .out_plane(out_plane), .out_pass(out_pass), .out_first(out_first),
        .out_eos(out_eos), .out_eop(out_eop), .out_eob(out_eob), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One scan; each cycle compares all fields to the arithmetic expectation.
    task automatic run_scan(input int c, input int r, input int p, input bit poke);
        int beat = 0;
        cfg_cols = (CW+1)'(c); cfg_rows = (RW+1)'(r); cfg_planes = (PW+1)'(p);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int pl = p - 1; pl >= 0; pl--)
            for (int ps = 0; ps < 3; ps++)
                for (int b = 0; b < r / 4; b++)
                    for (int cc = 0; cc < c; cc++)
                        for (int s = 0; s < 4; s++) begin
                            bit took = 1'b0;
                            bit e_eos = (s == 3) && (cc == c - 1);
                            bit e_eop = e_eos && (b == r / 4 - 1);
                            bit e_eob = e_eop && (ps == 2) && (pl == 0);
                            while (!took) begin
                                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                                out_ready = lfsr[0] | lfsr[3];
                                if (poke && beat == 7) begin
                                    start = 1'b1; cfg_cols = 4'd1; cfg_rows = 4'd4; cfg_planes = 3'd1;
                                end
                                chk(out_valid == 1'b1, "R2/R8 valid", int'(out_valid), 1);
                                chk(out_row == RW'(b * 4 + s) && out_col == CW'(cc), "R3/R4 coord",
                                    int'(out_row) * 100 + int'(out_col), (b * 4 + s) * 100 + cc);
                                chk(out_pass == 2'(ps), "R5 pass", int'(out_pass), ps);
                                chk(out_plane == PW'(pl), "R6 plane", int'(out_plane), pl);
                                chk(out_eos == e_eos && out_eop == e_eop, "R4/R5 markers",
                                    int'({out_eos, out_eop}), int'({e_eos, e_eop}));
                                chk(out_eob == e_eob, "R7 end of block", int'(out_eob), int'(e_eob));
                                chk(out_first == (beat == 0), "R2 first", int'(out_first), int'(beat == 0));
                                took = out_ready;
                                @(negedge clk);
                                start = 1'b0;
                                if (poke && beat == 7) begin  // R10 config restored; stream checks continue
                                    cfg_cols = (CW+1)'(c); cfg_rows = (RW+1)'(r); cfg_planes = (PW+1)'(p);
                                end
                            end
                            beat++;
                        end
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R7 idle after end", int'(out_valid), 0);
        chk(cfg_err == 1'b0, "R9 err clear on legal start", int'(cfg_err), 0);
    endtask

    task automatic bad_cfg(input int c, input int r, input int p);
        cfg_cols = (CW+1)'(c); cfg_rows = (RW+1)'(r); cfg_planes = (PW+1)'(p);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cfg_err == 1'b1, "R9 err set", int'(cfg_err), 1);
        chk(out_valid == 1'b0, "R9 no scan", int'(out_valid), 0);
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 still idle", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && cfg_err == 1'b0, "R1 reset", int'({out_valid, cfg_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_scan(3, 8, 2, 1'b1);  // R10
        for (int p = 1; p <= MAX_BP; p++)
            for (int r = 4; r <= MAX_H; r += 4)
                for (int c = 1; c <= MAX_W; c++)
                    run_scan(c, r, p, 1'b0);
        bad_cfg(4, 6, 2);
        bad_cfg(4, 0, 2);
        bad_cfg(0, 4, 2);
        bad_cfg(9, 4, 2);
        bad_cfg(4, 12, 2);
        bad_cfg(4, 4, 0);
        bad_cfg(4, 4, 5);
        run_scan(2, 4, 1, 1'b0);  // R9 legal start clears the flag
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog expired: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule